// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block sequences the operating states of a small microcontroller core: normal run, idle, power-down, the wake-up after power-down, the internal reset, and an emulation mode in which the core gives up its pins to an external tester. It runs on the oscillator-domain clock. Its outputs are clock enables for the CPU, the peripherals and the oscillator, an internal reset, a RAM-write inhibit, and an emulation flag.

Software enters idle or power-down by pulsing a request input. Idle gates only the CPU clock. It ends when an enabled interrupt is pending or when the reset pin is raised. Power-down also stops the oscillator. It ends when the reset pin is raised, or through a two-phase handshake on an enabled, level-configured external interrupt line. Driving that line low restarts the oscillator. The CPU clock returns only after a programmable stabilization count has run out and the line has gone high again.

The reset pin is filtered. It must stay high for a set number of running oscillator clocks before the internal reset asserts. The strobe pins are sampled around the release of the internal reset to decide whether emulation mode is entered.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: `int_rst_o` is high while `rst_ni` is low. It asserts on the 24th consecutive clock edge at which `rst_pin_i` is high and the oscillator is enabled (RST_MC=2 machine cycles of CLKS_PER_MC=12 clocks), so a shorter pulse causes no reset. It drops one edge after `rst_pin_i` is sampled low.
- R2: A pulse on `idle_req_i` in run mode drops `cpu_clk_en_o`, keeps `per_clk_en_o` and `osc_en_o` high, and sets `idle_flag_o`, all from the next edge.
- R3: In idle, `irq_pend_i` high returns the block to run at the next edge: `cpu_clk_en_o` goes high and `idle_flag_o` clears.
- R4: If `rst_pin_i` rises during idle, the CPU clock resumes at the next edge and `ram_inhibit_o` is high from that edge until one edge after `int_rst_o` asserts.
- R5: A pulse on `pd_req_i` in run mode drops `cpu_clk_en_o`, `per_clk_en_o` and `osc_en_o` and sets `pd_flag_o`. When `pd_req_i` and `idle_req_i` arrive together, power-down wins and `idle_flag_o` stays low.
- R6: In power-down, line i of `ext_int_n_i` going low restarts the oscillator at the next edge when `ext_int_en_i[i]`=1 and `ext_int_edge_i[i]`=0 (level mode). Count the edge that first samples the line low as edge 1, with L = `stab_len_i` and the line sampled high again from edge h+1 on. The CPU clock then returns at edge max(L+2, h+1), and `pd_flag_o` clears at the same edge.
- R7: In power-down, `irq_pend_i` and any external line that is disabled or configured as edge (`ext_int_edge_i[i]`=1) have no effect: `osc_en_o` stays low.
- R8: Raising `rst_pin_i` in power-down enables the oscillator at the next edge. The reset filter then counts from the following edge, so `int_rst_o` asserts at edge 25. After that, the block returns to run.
- R9: Emulation mode (`emu_mode_o`=1) is entered when `ale_pin_i` is low and `psen_pin_i` is high on the last edge with `int_rst_o` high, and `ale_pin_i` is still low on the next edge. Otherwise `emu_mode_o` stays low.
- R10: In emulation mode, idle and power-down requests are ignored and the oscillator stays on. The next internal reset clears `emu_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-domain clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | Synchronized reset pin level, active high |
| idle_req_i | input | 1 | Software request pulse to enter idle |
| pd_req_i | input | 1 | Software request pulse to enter power-down |
| irq_pend_i | input | 1 | Some enabled interrupt is pending |
| ext_int_n_i | input | 2 | External interrupt line levels, active low |
| ext_int_en_i | input | 2 | External interrupt line enables |
| ext_int_edge_i | input | 2 | 1 = edge mode, 0 = level mode per line |
| ale_pin_i | input | 1 | Address-latch strobe pin level |
| psen_pin_i | input | 1 | Program-strobe pin level |
| stab_len_i | input | 8 | Oscillator stabilization count after wake |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| int_rst_o | output | 1 | Internal reset, active high |
| ram_inhibit_o | output | 1 | Blocks internal RAM writes |
| emu_mode_o | output | 1 | Emulation mode: one port floats, the rest pull weakly high |
| idle_flag_o | output | 1 | Idle request bit, cleared on exit |
| pd_flag_o | output | 1 | Power-down request bit, cleared on exit |

## Verification
The bench drives a reset pulse one clock short of the limit and expects no reset. A filter that counts off by one would reset there. Wake-up from power-down is swept over stabilization lengths against release times of the interrupt line. A design that ignores either phase of the handshake would give the CPU clock back too early. A design that counts the filter during the dead-oscillator cycle would assert reset one edge early. The bench also feeds edge-mode and disabled interrupt lines to a sleeping block, and these must not wake it. Emulation entry is tried with the strobe released at the reset edge itself, and that attempt must fail; a detector that samples only during reset would enter emulation anyway.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_PD   = 2'd2,
    PM_WAKE = 2'd3
  } pm_state_e;
endpackage

// File: rtl/prc_rst_filter.sv
module prc_rst_filter #(
  parameter int RST_CLKS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_i,
  input  logic osc_run_i,
  output logic int_rst_o
);
  localparam int CW = $clog2(RST_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else if (!rst_pin_i) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (osc_run_i) begin
      if (cnt_q == LAST) rst_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign int_rst_o = rst_q;

  AST_RST_NEEDS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(rst_pin_i)); // R1
  AST_RST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_pin_i |=> !int_rst_o); // R1
endmodule

// File: rtl/prc_stab_timer.sv
module prc_stab_timer #(
  parameter int STAB_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [STAB_W-1:0] len_i,
  output logic              done_o
);
  logic [STAB_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= len_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_STAB_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && done_o) |=> done_o); // R6
endmodule

// File: rtl/prc_emu_detect.sv
module prc_emu_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_rst_i,
  input  logic ale_pin_i,
  input  logic psen_pin_i,
  output logic emu_mode_o
);
  logic arm_q, emu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      emu_q <= 1'b0;
    end else if (int_rst_i) begin
      arm_q <= !ale_pin_i && psen_pin_i;
      emu_q <= 1'b0;
    end else if (arm_q) begin
      // strap must still hold on the edge after release
      emu_q <= !ale_pin_i;
      arm_q <= 1'b0;
    end
  end

  assign emu_mode_o = emu_q;

  AST_EMU_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(emu_q) |-> $past(int_rst_i, 2)); // R9
  AST_EMU_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_i |=> !emu_mode_o); // R10
endmodule

// File: rtl/prc_mode_fsm.sv
module prc_mode_fsm
  import pwr_rst_pkg::*;
#(
  parameter int N_EXT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_rst_i,
  input  logic             rst_pin_i,
  input  logic             emu_i,
  input  logic             idle_req_i,
  input  logic             pd_req_i,
  input  logic             irq_pend_i,
  input  logic [N_EXT-1:0] ext_int_n_i,
  input  logic [N_EXT-1:0] ext_int_en_i,
  input  logic [N_EXT-1:0] ext_int_edge_i,
  input  logic             stab_done_i,
  output logic             stab_load_o,
  output logic             stab_run_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic             ram_inhibit_o,
  output logic             idle_flag_o,
  output logic             pd_flag_o
);
  pm_state_e        state_q;
  logic [N_EXT-1:0] lvl_low;
  logic             wake_act;
  logic             inhibit_q;

  // only enabled, level-configured lines may wake from power-down
  for (genvar i = 0; i < N_EXT; i++) begin : g_wake
    assign lvl_low[i] = ext_int_en_i[i] && !ext_int_edge_i[i] && !ext_int_n_i[i];
  end
  assign wake_act = |lvl_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PM_RUN;
      inhibit_q <= 1'b0;
    end else if (int_rst_i) begin
      state_q   <= PM_RUN;
      inhibit_q <= 1'b0;
    end else begin
      inhibit_q <= rst_pin_i && (inhibit_q || state_q == PM_IDLE);
      unique case (state_q)
        PM_RUN: begin
          if (!emu_i) begin
            if (pd_req_i)        state_q <= PM_PD;
            else if (idle_req_i) state_q <= PM_IDLE;
          end
        end
        PM_IDLE: begin
          if (rst_pin_i || irq_pend_i) state_q <= PM_RUN;
        end
        PM_PD: begin
          if (rst_pin_i || wake_act) state_q <= PM_WAKE;
        end
        PM_WAKE: begin
          if (stab_done_i && !wake_act) state_q <= PM_RUN;
        end
        default: state_q <= PM_RUN;
      endcase
    end
  end

  assign stab_load_o   = (state_q == PM_PD) && (rst_pin_i || wake_act);
  assign stab_run_o    = (state_q == PM_WAKE);
  assign cpu_clk_en_o  = (state_q == PM_RUN);
  assign per_clk_en_o  = (state_q == PM_RUN) || (state_q == PM_IDLE);
  assign osc_en_o      = (state_q != PM_PD);
  assign ram_inhibit_o = inhibit_q;
  assign idle_flag_o   = (state_q == PM_IDLE);
  assign pd_flag_o     = (state_q == PM_PD) || (state_q == PM_WAKE);

  AST_IDLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_IDLE && irq_pend_i && !int_rst_i) |=> cpu_clk_en_o); // R3
  AST_INHIBIT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inhibit_q) |-> $past(state_q == PM_IDLE)); // R4
  AST_REQ_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_RUN && pd_req_i && idle_req_i && !int_rst_i && !emu_i)
      |=> (pd_flag_o && !idle_flag_o)); // R5
  AST_WAKE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_WAKE && !stab_done_i && !int_rst_i) |=> !cpu_clk_en_o); // R6
  AST_PD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_PD && !wake_act && !rst_pin_i && !int_rst_i) |=> !osc_en_o); // R7
  AST_EMU_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_i && state_q == PM_RUN) |=> osc_en_o); // R10
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl #(
  parameter int CLKS_PER_MC = 12,
  parameter int RST_MC      = 2,
  parameter int STAB_W      = 8,
  parameter int N_EXT       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              idle_req_i,
  input  logic              pd_req_i,
  input  logic              irq_pend_i,
  input  logic [N_EXT-1:0]  ext_int_n_i,
  input  logic [N_EXT-1:0]  ext_int_en_i,
  input  logic [N_EXT-1:0]  ext_int_edge_i,
  input  logic              ale_pin_i,
  input  logic              psen_pin_i,
  input  logic [STAB_W-1:0] stab_len_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_en_o,
  output logic              int_rst_o,
  output logic              ram_inhibit_o,
  output logic              emu_mode_o,
  output logic              idle_flag_o,
  output logic              pd_flag_o
);
  localparam int RST_CLKS = CLKS_PER_MC * RST_MC;

  logic int_rst, emu, osc_en, stab_load, stab_run, stab_done;

  prc_rst_filter #(.RST_CLKS(RST_CLKS)) u_rst_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_pin_i (rst_pin_i),
    .osc_run_i (osc_en),
    .int_rst_o (int_rst)
  );

  prc_stab_timer #(.STAB_W(STAB_W)) u_stab_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stab_load),
    .run_i  (stab_run),
    .len_i  (stab_len_i),
    .done_o (stab_done)
  );

  prc_emu_detect u_emu_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_rst_i  (int_rst),
    .ale_pin_i  (ale_pin_i),
    .psen_pin_i (psen_pin_i),
    .emu_mode_o (emu)
  );

  prc_mode_fsm #(.N_EXT(N_EXT)) u_mode_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .int_rst_i      (int_rst),
    .rst_pin_i      (rst_pin_i),
    .emu_i          (emu),
    .idle_req_i     (idle_req_i),
    .pd_req_i       (pd_req_i),
    .irq_pend_i     (irq_pend_i),
    .ext_int_n_i    (ext_int_n_i),
    .ext_int_en_i   (ext_int_en_i),
    .ext_int_edge_i (ext_int_edge_i),
    .stab_done_i    (stab_done),
    .stab_load_o    (stab_load),
    .stab_run_o     (stab_run),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .per_clk_en_o   (per_clk_en_o),
    .osc_en_o       (osc_en),
    .ram_inhibit_o  (ram_inhibit_o),
    .idle_flag_o    (idle_flag_o),
    .pd_flag_o      (pd_flag_o)
  );

  assign osc_en_o   = osc_en;
  assign int_rst_o  = int_rst;
  assign emu_mode_o = emu;
endmodule

// File: tb/pwr_rst_ctrl_bench.sv
module pwr_rst_ctrl_bench;
  localparam int RSTN = 24;
  localparam int NV   = 6;
  // {line, stab_len, low_edges}
  localparam int WAKE_VEC [NV][3] = '{
    '{0, 0, 1}, '{1, 3, 1}, '{0, 3, 10}, '{1, 10, 4}, '{0, 5, 7}, '{1, 0, 6}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_pin_i = 1'b0;
  logic       idle_req_i = 1'b0, pd_req_i = 1'b0, irq_pend_i = 1'b0;
  logic [1:0] ext_int_n_i = 2'b11, ext_int_en_i = 2'b11, ext_int_edge_i = 2'b00;
  logic       ale_pin_i = 1'b1, psen_pin_i = 1'b1;
  logic [7:0] stab_len_i = 8'd0;
  logic cpu_clk_en_o, per_clk_en_o, osc_en_o, int_rst_o, ram_inhibit_o;
  logic emu_mode_o, idle_flag_o, pd_flag_o;

  int checks = 0, failures = 0;

  always #5 clk_i = ~clk_i;

  pwr_rst_ctrl u_pwr_rst_ctrl (
    .clk_i, .rst_ni, .rst_pin_i, .idle_req_i, .pd_req_i, .irq_pend_i,
    .ext_int_n_i, .ext_int_en_i, .ext_int_edge_i, .ale_pin_i, .psen_pin_i,
    .stab_len_i, .cpu_clk_en_o, .per_clk_en_o, .osc_en_o, .int_rst_o,
    .ram_inhibit_o, .emu_mode_o, .idle_flag_o, .pd_flag_o
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_pd();
    pd_req_i = 1'b1; step(1); pd_req_i = 1'b0;
  endtask

  task automatic full_reset();
    rst_pin_i = 1'b1; step(RSTN + 1); rst_pin_i = 1'b0; step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(2);
    check(int_rst_o == 1, "R1 por", int_rst_o, 1);
    check(cpu_clk_en_o && !emu_mode_o && !idle_flag_o && !pd_flag_o, "R1 por state",
          {cpu_clk_en_o, emu_mode_o, idle_flag_o, pd_flag_o}, 8);
    rst_ni = 1'b1; step(1);
    check(int_rst_o == 0, "R1 por release", int_rst_o, 0);

    // R1: one clock short, then full length
    rst_pin_i = 1'b1; step(RSTN - 1); rst_pin_i = 1'b0; step(1);
    check(int_rst_o == 0, "R1 short pulse", int_rst_o, 0);
    rst_pin_i = 1'b1; step(RSTN - 1);
    check(int_rst_o == 0, "R1 edge n-1", int_rst_o, 0);
    step(1);
    check(int_rst_o == 1, "R1 edge n", int_rst_o, 1);
    rst_pin_i = 1'b0; step(1);
    check(int_rst_o == 0, "R1 release", int_rst_o, 0);

    // R2 / R3
    idle_req_i = 1'b1; step(1); idle_req_i = 1'b0;
    check(!cpu_clk_en_o && per_clk_en_o && osc_en_o && idle_flag_o, "R2 idle",
          {cpu_clk_en_o, per_clk_en_o, osc_en_o, idle_flag_o}, 7);
    step(3);
    check(!cpu_clk_en_o, "R2 idle holds", cpu_clk_en_o, 0);
    irq_pend_i = 1'b1; step(1); irq_pend_i = 1'b0;
    check(cpu_clk_en_o && !idle_flag_o, "R3 idle exit", {cpu_clk_en_o, idle_flag_o}, 2);

    // R4
    idle_req_i = 1'b1; step(1); idle_req_i = 1'b0;
    rst_pin_i = 1'b1; step(1);
    check(cpu_clk_en_o && ram_inhibit_o && !int_rst_o, "R4 window",
          {cpu_clk_en_o, ram_inhibit_o, int_rst_o}, 6);
    step(RSTN - 1);
    check(int_rst_o && ram_inhibit_o, "R4 reset edge", {int_rst_o, ram_inhibit_o}, 3);
    step(1);
    check(!ram_inhibit_o, "R4 inhibit clear", ram_inhibit_o, 0);
    rst_pin_i = 1'b0; step(1);

    // R5 priority
    pd_req_i = 1'b1; idle_req_i = 1'b1; step(1); pd_req_i = 1'b0; idle_req_i = 1'b0;
    check(pd_flag_o && !idle_flag_o, "R5 priority", {pd_flag_o, idle_flag_o}, 2);
    check(!cpu_clk_en_o && !per_clk_en_o && !osc_en_o, "R5 clocks off",
          {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 0);

    // R7: edge-mode line 0, disabled line 1, pending irq
    ext_int_en_i = 2'b01; ext_int_edge_i = 2'b01; ext_int_n_i = 2'b00; irq_pend_i = 1'b1;
    step(5);
    check(!osc_en_o && pd_flag_o, "R7 no wake", osc_en_o, 0);
    ext_int_n_i = 2'b11; irq_pend_i = 1'b0; ext_int_en_i = 2'b11; ext_int_edge_i = 2'b00;
    step(1);
    check(!osc_en_o, "R7 still down", osc_en_o, 0);

    // R8 reset out of power-down
    stab_len_i = 8'd255;
    rst_pin_i = 1'b1; step(1);
    check(osc_en_o && !int_rst_o, "R8 osc restart", {osc_en_o, int_rst_o}, 2);
    step(RSTN - 1);
    check(!int_rst_o, "R8 edge 24", int_rst_o, 0);
    step(1);
    check(int_rst_o, "R8 edge 25", int_rst_o, 1);
    step(1);
    check(cpu_clk_en_o && !pd_flag_o, "R8 run", {cpu_clk_en_o, pd_flag_o}, 2);
    rst_pin_i = 1'b0; step(1);

    // R6 handshake table
    for (int v = 0; v < NV; v++) begin
      int line = WAKE_VEC[v][0];
      int len  = WAKE_VEC[v][1];
      int h    = WAKE_VEC[v][2];
      int exp  = (len + 2 > h + 1) ? len + 2 : h + 1;
      int got  = -1;
      stab_len_i = 8'(len);
      pulse_pd();
      check(!osc_en_o && pd_flag_o, "R6 enter pd", osc_en_o, 0);
      ext_int_n_i[line] = 1'b0;
      for (int e = 1; e <= 40; e++) begin
        step(1);
        if (e == 1) check(osc_en_o && !cpu_clk_en_o, "R6 osc first",
                          {osc_en_o, cpu_clk_en_o}, 2);
        if (e == h) ext_int_n_i[line] = 1'b1;
        if (cpu_clk_en_o && got < 0) got = e;
      end
      check(got == exp, "R6 wake edge", got, exp);
      check(!pd_flag_o, "R6 flag clear", pd_flag_o, 0);
    end

    // R9 entry and R10 behaviour
    ale_pin_i = 1'b0; rst_pin_i = 1'b1; step(RSTN + 1);
    rst_pin_i = 1'b0; step(3); ale_pin_i = 1'b1;
    check(emu_mode_o, "R9 entry", emu_mode_o, 1);
    pulse_pd();
    check(osc_en_o && !pd_flag_o, "R10 pd ignored", {osc_en_o, pd_flag_o}, 2);
    idle_req_i = 1'b1; step(1); idle_req_i = 1'b0;
    check(cpu_clk_en_o && !idle_flag_o, "R10 idle ignored", {cpu_clk_en_o, idle_flag_o}, 2);
    rst_pin_i = 1'b1; step(RSTN + 1);
    check(!emu_mode_o, "R10 reset clears", emu_mode_o, 0);
    rst_pin_i = 1'b0; step(3);
    check(!emu_mode_o, "R10 stays normal", emu_mode_o, 0);

    // R9 negatives
    ale_pin_i = 1'b0; psen_pin_i = 1'b0; full_reset(); step(2);
    check(!emu_mode_o, "R9 psen low", emu_mode_o, 0);
    psen_pin_i = 1'b1;
    rst_pin_i = 1'b1; step(RSTN + 1);
    rst_pin_i = 1'b0; ale_pin_i = 1'b1; step(3);
    check(!emu_mode_o, "R9 ale released at edge", emu_mode_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule